// File: doc/BRIEF.md
# Layer Display Address Generator

This block walks one display layer through video memory. For every screen pixel that the raster timing announces, it produces the byte address to fetch from a 1 MB memory, a flag saying whether the layer covers that pixel, and the bit index of the pixel inside the fetched byte. A downstream decoder uses the bit index to pick the pixel's bits. Palette lookup and the memory itself sit elsewhere.

A 16-byte control block is written one byte at a time into a shadow copy. The shadow becomes the active set at every frame start. It is also loaded part-way down the screen once a programmed number of lines has been drawn with the current set, so a layer can change mode, base or zoom mid-frame. The active set holds these settings:

- the base address and the line stride;
- the colour depth: 1, 2, 4, 8 or 16 bits per pixel;
- the horizontal and vertical zoom factors;
- the sub-pixel start offsets;
- the window position and size;
- an enable.

Top module: `layer_addr_gen`

## Requirements
- R1: The control block is 16 bytes; a multi-byte field puts its most significant byte at the lowest index. Byte 0 holds the enable in bit 7 and the format in bits 2:0. Bytes 1-3 hold the base address in their low 20 bits. Bytes 4-5 hold the stride. Byte 6 holds Xscale-1 in bits 7:4 and Yscale-1 in bits 3:0. Byte 7 holds the X offset in bits 7:4 and the Y offset in bits 3:0. Bytes 8-9 hold X start and bytes 10-11 hold Y start, each in the low 10 bits. Bytes 12-15 form a 32-bit word with width in bits 31:22, height in bits 21:12 and line count in bits 11:2. Writes go to the shadow, and frame_start copies the shadow into the active set.
- R2: On screen line y == Ystart the line address becomes base + Yoffset*stride. The line that frame_start opens is line 0, and every address wraps modulo 2^20.
- R3: On later lines inside the vertical window, the line address grows by the stride once every Yscale screen lines. The line address never changes except on frame_start or line_start.
- R4: Each image pixel covers Xscale consecutive in-window screen pixels, and each image line covers Yscale screen lines.
- R5: Format codes 0..4 give 1, 2, 4, 8 and 16 bits per pixel (bpp). pix_addr = line address + floor(col*bpp/8), so in 16-bit mode the address steps by 2 per image pixel.
- R6: pix_bit = 7 - (col*bpp mod 8). It is always 7 in 8-bit and 16-bit modes.
- R7: The image column is col = Xoffset + (x-Xstart)/Xscale and the image row is row = Yoffset + (y-Ystart)/Yscale, so the offsets skip whole image pixels at the window's top and left edges.
- R8: pix_en is high only when Xstart <= x < Xstart+width and Ystart <= y < Ystart+height. Outside that window pix_en is low, and pix_addr and pix_bit keep their previous values.
- R9: With the enable bit at 0, or with a format code of 5, 6 or 7, pix_en stays low for every pixel.
- R10: With a line count N other than 0, the line_start that follows N lines drawn with the active set loads the shadow. With N = 0 the set is loaded only at frame_start.
- R11: Shadow writes leave the outputs unchanged until the next load.
- R12: After reset pix_en is 0, pix_addr is 0 and pix_bit is 7. The active set is all zero, so the layer is off.
- R13: A pix_tick at a clock edge updates the outputs at that edge for pixel x, where x counts the ticks since the last strobe. frame_start sets the line counter y to 0, and line_start increments y. Both strobes reset x and drive pix_en low at their edge. A pix_tick in the same cycle as a strobe is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for one shadow control byte |
| cfg_idx | input | 4 | Control byte index |
| cfg_byte | input | 8 | Control byte value |
| frame_start | input | 1 | Start of frame, opens line 0 |
| line_start | input | 1 | Start of the next screen line |
| pix_tick | input | 1 | Advance one screen pixel |
| pix_addr | output | 20 | Byte address for the current pixel |
| pix_en | output | 1 | Layer covers the current pixel |
| pix_bit | output | 3 | Most significant bit index of the pixel inside the byte |

## Verification
A wrong stride accumulator or row-zoom counter shows as a wrong pix_addr on the first in-window pixel of the affected screen line, one cycle after that tick. An off-by-one horizontal zoom counter or bit position moves pix_addr or pix_bit within Xscale pixels of the window's left edge. A faulty line countdown shows the next control set one line early or late, and a faulty hold shows as addresses changing while pix_en is low. The scoreboard predicts every tick from the closed formulas for row and column, so any of these appears at the next compare.

// File: rtl/layer_pkg.sv
`timescale 1ns/1ps
package layer_pkg;
    parameter int ADDR_W    = 20;
    parameter int COORD_W   = 10;
    parameter int STRIDE_W  = 16;
    parameter int ZOOM_W    = 4;
    parameter int CFG_BYTES = 16;

    localparam int CFG_BITS = CFG_BYTES * 8;
    localparam int IDX_W    = $clog2(CFG_BYTES);
    localparam int POS_W    = COORD_W + ZOOM_W + 2;
    localparam logic [2:0] FMT_LAST = 3'd4;

    // Big-endian image of the 16-byte control block: byte 0 is the top byte.
    typedef struct packed {
        logic                      enable;
        logic [3:0]                rsv0;
        logic [2:0]                fmt;
        logic [23-ADDR_W:0]        rsv1;
        logic [ADDR_W-1:0]         base;
        logic [STRIDE_W-1:0]       stride;
        logic [ZOOM_W-1:0]         xzoom;
        logic [ZOOM_W-1:0]         yzoom;
        logic [ZOOM_W-1:0]         xsub;
        logic [ZOOM_W-1:0]         ysub;
        logic [15-COORD_W:0]       rsv2;
        logic [COORD_W-1:0]        xstart;
        logic [15-COORD_W:0]       rsv3;
        logic [COORD_W-1:0]        ystart;
        logic [COORD_W-1:0]        width;
        logic [COORD_W-1:0]        height;
        logic [COORD_W-1:0]        lines;
        logic [31-3*COORD_W:0]     rsv4;
    } layer_cfg_t;
endpackage

// File: rtl/lag_cfg_bank.sv
`timescale 1ns/1ps
module lag_cfg_bank
    import layer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [IDX_W-1:0] cfg_idx,
    input  logic [7:0]       cfg_byte,
    input  logic             frame_start,
    input  logic             line_start,
    output layer_cfg_t       cfg_q,
    output layer_cfg_t       cfg_nx
);
    typedef struct packed {
        logic [CFG_BITS-1:0] sh;
        layer_cfg_t          act;
        logic [COORD_W-1:0]  lcnt;
    } bank_t;

    bank_t      bank_d, bank_q;
    layer_cfg_t sh_cfg;
    logic       reload;

    always_comb begin
        bank_d = bank_q;
        sh_cfg = layer_cfg_t'(bank_q.sh);
        reload = frame_start ||
                 (line_start && (bank_q.act.lines != '0) && (bank_q.lcnt == COORD_W'(1)));
        if (reload) begin
            bank_d.act  = sh_cfg;
            bank_d.lcnt = sh_cfg.lines;
        end else if (line_start && (bank_q.lcnt != '0)) begin
            bank_d.lcnt = bank_q.lcnt - COORD_W'(1);
        end
        if (cfg_we) begin
            bank_d.sh[CFG_BITS-1-8*int'(cfg_idx) -: 8] = cfg_byte;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign cfg_q  = bank_q.act;
    assign cfg_nx = bank_d.act;

    AST_LCNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        bank_q.lcnt <= bank_q.act.lines); // R10
    AST_ACT_ONLY_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_start && !line_start) |=> $stable(bank_q.act)); // R11
endmodule

// File: rtl/lag_vstep.sv
`timescale 1ns/1ps
module lag_vstep
    import layer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              line_start,
    input  layer_cfg_t        cfg_nx,
    output logic [ADDR_W-1:0] line_addr,
    output logic              v_in
);
    localparam int CW1 = COORD_W + 1;

    typedef struct packed {
        logic [COORD_W-1:0] y;
        logic [ADDR_W-1:0]  line_addr;
        logic [ZOOM_W-1:0]  yz;
        logic               v_in;
    } vst_t;

    vst_t               v_d, v_q;
    logic [COORD_W-1:0] ny;
    logic [CW1-1:0]     y_end;
    logic               in_y;
    logic               unused_cfg;

    assign unused_cfg = ^cfg_nx;

    always_comb begin
        v_d   = v_q;
        ny    = frame_start ? '0 : v_q.y + COORD_W'(1);
        y_end = {1'b0, cfg_nx.ystart} + {1'b0, cfg_nx.height};
        in_y  = (ny >= cfg_nx.ystart) && ({1'b0, ny} < y_end);
        if (frame_start || line_start) begin
            v_d.y    = ny;
            v_d.v_in = in_y;
            if (ny == cfg_nx.ystart) begin
                v_d.line_addr = cfg_nx.base + ADDR_W'(cfg_nx.ysub) * ADDR_W'(cfg_nx.stride);
                v_d.yz        = '0;
            end else if (in_y) begin
                if (v_q.yz >= cfg_nx.yzoom) begin
                    v_d.yz        = '0;
                    v_d.line_addr = v_q.line_addr + ADDR_W'(cfg_nx.stride);
                end else begin
                    v_d.yz = v_q.yz + ZOOM_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) v_q <= '0;
        else        v_q <= v_d;
    end

    assign line_addr = v_q.line_addr;
    assign v_in      = v_q.v_in;

    AST_LINE_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_start && !line_start) |=> $stable(v_q.line_addr)); // R3
endmodule

// File: rtl/lag_hstep.sv
`timescale 1ns/1ps
module lag_hstep
    import layer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              line_start,
    input  logic              pix_tick,
    input  layer_cfg_t        cfg,
    input  logic [ADDR_W-1:0] line_addr,
    input  logic              v_in,
    output logic [ADDR_W-1:0] pix_addr,
    output logic              pix_en,
    output logic [2:0]        pix_bit
);
    localparam int CW1 = COORD_W + 1;

    typedef struct packed {
        logic [COORD_W-1:0] x;
        logic [POS_W-1:0]   pos;
        logic [ZOOM_W-1:0]  xz;
        logic [ADDR_W-1:0]  addr;
        logic [2:0]         bitix;
        logic               en;
    } hst_t;

    hst_t               h_d, h_q;
    logic [CW1-1:0]     x_end;
    logic               in_x, vis;
    logic [POS_W-1:0]   step, first_pos, cur_pos;
    logic [ZOOM_W-1:0]  cur_xz;
    logic               unused_cfg;

    assign unused_cfg = ^cfg;

    always_comb begin
        h_d       = h_q;
        x_end     = {1'b0, cfg.xstart} + {1'b0, cfg.width};
        in_x      = (h_q.x >= cfg.xstart) && ({1'b0, h_q.x} < x_end);
        vis       = cfg.enable && (cfg.fmt <= FMT_LAST) && in_x && v_in;
        step      = POS_W'(1) << cfg.fmt;
        first_pos = POS_W'(cfg.xsub) << cfg.fmt;
        cur_pos   = h_q.pos;
        cur_xz    = h_q.xz;
        if (h_q.x == cfg.xstart) begin
            cur_pos = first_pos;
            cur_xz  = '0;
        end else if (h_q.xz >= cfg.xzoom) begin
            cur_pos = h_q.pos + step;
            cur_xz  = '0;
        end else begin
            cur_xz  = h_q.xz + ZOOM_W'(1);
        end

        if (frame_start || line_start) begin
            h_d.x  = '0;
            h_d.en = 1'b0;
        end else if (pix_tick) begin
            h_d.x = h_q.x + COORD_W'(1);
            if (vis) begin
                h_d.pos   = cur_pos;
                h_d.xz    = cur_xz;
                h_d.addr  = line_addr + ADDR_W'(cur_pos >> 3);
                h_d.bitix = 3'd7 - cur_pos[2:0];
                h_d.en    = 1'b1;
            end else begin
                h_d.en = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_q       <= '0;
            h_q.bitix <= 3'd7;
        end else begin
            h_q <= h_d;
        end
    end

    assign pix_addr = h_q.addr;
    assign pix_en   = h_q.en;
    assign pix_bit  = h_q.bitix;

    AST_EN_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(h_q.en) |-> $past(pix_tick)); // R13
    AST_STROBE_CLEARS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start || line_start) |=> !h_q.en); // R13
    AST_ADDR_HELD_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        !h_q.en |-> ($stable(h_q.addr) && $stable(h_q.bitix))); // R8
    AST_WIDE_FMT_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (h_q.en && cfg.fmt >= 3'd3) |-> (h_q.bitix == 3'd7)); // R6
endmodule

// File: rtl/layer_addr_gen.sv
`timescale 1ns/1ps
module layer_addr_gen
    import layer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [7:0]        cfg_byte,
    input  logic              frame_start,
    input  logic              line_start,
    input  logic              pix_tick,
    output logic [ADDR_W-1:0] pix_addr,
    output logic              pix_en,
    output logic [2:0]        pix_bit
);
    layer_cfg_t        cfg_q, cfg_nx;
    logic [ADDR_W-1:0] line_addr;
    logic              v_in;

    lag_cfg_bank u_bank (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_byte(cfg_byte), .frame_start(frame_start), .line_start(line_start),
        .cfg_q(cfg_q), .cfg_nx(cfg_nx)
    );

    lag_vstep u_vert (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .line_start(line_start), .cfg_nx(cfg_nx),
        .line_addr(line_addr), .v_in(v_in)
    );

    lag_hstep u_horz (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .line_start(line_start), .pix_tick(pix_tick), .cfg(cfg_q),
        .line_addr(line_addr), .v_in(v_in),
        .pix_addr(pix_addr), .pix_en(pix_en), .pix_bit(pix_bit)
    );
endmodule

// File: tb/layer_addr_gen_bench.sv
`timescale 1ns/1ps
module layer_addr_gen_bench;
    typedef struct {
        int en; int fmt; int base; int stride; int xsc; int ysc;
        int xsub; int ysub; int xs; int ys; int w; int h; int lines;
    } lset_t;

    typedef struct {
        bit    en;
        int    addr;
        int    bitv;
        string tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_idx = '0;
    logic [7:0]  cfg_byte = '0;
    logic        frame_start = 1'b0;
    logic        line_start = 1'b0;
    logic        pix_tick = 1'b0;
    logic [19:0] pix_addr;
    logic        pix_en;
    logic [2:0]  pix_bit;

    exp_t sb[$];
    int   checks = 0;
    int   errors = 0;
    int   last_addr = 0;
    int   last_bit = 7;
    bit   tick_seen = 1'b0;
    bit   done = 1'b0;

    always #2.5 clk = ~clk;

    layer_addr_gen u_layer_addr_gen (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_byte(cfg_byte), .frame_start(frame_start), .line_start(line_start),
        .pix_tick(pix_tick), .pix_addr(pix_addr), .pix_en(pix_en), .pix_bit(pix_bit)
    );

    function automatic lset_t mk(int en, int fmt, int base, int stride, int xsc, int ysc,
                                 int xsub, int ysub, int xs, int ys, int w, int h, int lines);
        lset_t c;
        c.en = en; c.fmt = fmt; c.base = base; c.stride = stride; c.xsc = xsc; c.ysc = ysc;
        c.xsub = xsub; c.ysub = ysub; c.xs = xs; c.ys = ys; c.w = w; c.h = h; c.lines = lines;
        return c;
    endfunction

    // R1 layout, built from the requirement text
    function automatic logic [127:0] pack(lset_t c);
        logic [3:0] xz, yz;
        xz = 4'(c.xsc - 1);
        yz = 4'(c.ysc - 1);
        return {c.en[0], 4'b0, c.fmt[2:0], 4'b0, c.base[19:0], c.stride[15:0],
                xz, yz, c.xsub[3:0], c.ysub[3:0], 6'b0, c.xs[9:0], 6'b0, c.ys[9:0],
                c.w[9:0], c.h[9:0], c.lines[9:0], 2'b0};
    endfunction

    function automatic exp_t model(lset_t c, int x, int y, string tg);
        exp_t e;
        int col, row, bp;
        e.tag = tg;
        if (c.en != 0 && c.fmt <= 4 && x >= c.xs && x < c.xs + c.w &&
            y >= c.ys && y < c.ys + c.h) begin
            row = c.ysub + (y - c.ys) / c.ysc;
            col = c.xsub + (x - c.xs) / c.xsc;
            bp  = col << c.fmt;
            last_addr = (c.base + row * c.stride + bp / 8) & 'hFFFFF;
            last_bit  = 7 - (bp % 8);
            e.en = 1'b1;
        end else begin
            e.en = 1'b0;
        end
        e.addr = last_addr;
        e.bitv = last_bit;
        return e;
    endfunction

    always @(posedge clk) tick_seen <= pix_tick;

    // Monitor: compare the outputs for every clocked tick.
    always @(negedge clk) begin
        exp_t e;
        if (tick_seen && !done) begin
            checks++;
            if (sb.size() == 0) begin
                errors++;
                $display("FAIL R13: got an output update, expected no pending item");
            end else begin
                e = sb.pop_front();
                if (pix_en !== e.en || pix_addr !== e.addr[19:0] || pix_bit !== e.bitv[2:0]) begin
                    errors++;
                    $display("FAIL %s: got en=%0b addr=%05h bit=%0d, expected en=%0b addr=%05h bit=%0d",
                             e.tag, pix_en, pix_addr, pix_bit, e.en, e.addr[19:0], e.bitv);
                end
            end
        end
    end

    task automatic write_set(lset_t c);
        logic [127:0] v;
        v = pack(c);
        for (int k = 0; k < 16; k++) begin
            cfg_we   = 1'b1;
            cfg_idx  = 4'(k);
            cfg_byte = v[127-8*k -: 8];
            @(negedge clk);
        end
        cfg_we = 1'b0;
    endtask

    task automatic strobe(bit fr);
        if (fr) frame_start = 1'b1;
        else    line_start  = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        line_start  = 1'b0;
        checks++;
        if (pix_en !== 1'b0) begin
            errors++;
            $display("FAIL R13: strobe got pix_en=%0b expected 0", pix_en);
        end
    endtask

    task automatic ticks(lset_t c, int y, int n, string tg);
        for (int x = 0; x < n; x++) begin
            sb.push_back(model(c, x, y, tg));
            pix_tick = 1'b1;
            @(negedge clk);
        end
        pix_tick = 1'b0;
    endtask

    task automatic frame(lset_t c, int nl, int nt, string tg);
        strobe(1'b1);
        ticks(c, 0, nt, tg);
        for (int y = 1; y < nl; y++) begin
            strobe(1'b0);
            ticks(c, y, nt, tg);
        end
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL R13 watchdog: got no finish, expected the run to end");
            summary();
            $finish;
        end
    end

    initial begin
        lset_t c0, ca, cb, cc, cd, ce, cf, cg, ch, ci;
        c0 = mk(0, 0, 0, 0, 1, 1, 0, 0, 0, 0, 0, 0, 0);
        ca = mk(1, 0, 'h12340, 'h40, 1, 1, 3, 1, 2, 1, 20, 3, 0);
        cb = mk(1, 1, 'h00100, 'h20, 3, 2, 5, 0, 0, 0, 30, 6, 0);
        cc = mk(1, 2, 'h40000, 'h100, 2, 1, 9, 2, 4, 2, 16, 3, 0);
        cd = mk(1, 3, 'hFFFF0, 'h8, 1, 3, 0, 0, 0, 0, 24, 6, 0);
        ce = mk(1, 4, 'h02000, 'h200, 2, 1, 1, 0, 1, 0, 10, 2, 0);
        cf = mk(0, 0, 'h12340, 'h40, 1, 1, 3, 1, 2, 1, 20, 3, 0);
        cg = mk(1, 6, 'h12340, 'h40, 1, 1, 0, 0, 0, 0, 20, 3, 0);
        ch = mk(1, 0, 'h30000, 'h20, 1, 1, 0, 0, 0, 0, 16, 10, 3);
        ci = mk(1, 3, 'h80000, 'h10, 1, 1, 0, 0, 0, 3, 16, 10, 0);

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (pix_en !== 1'b0 || pix_addr !== 20'h0 || pix_bit !== 3'd7) begin
            errors++;
            $display("FAIL R12: got en=%0b addr=%05h bit=%0d, expected en=0 addr=00000 bit=7",
                     pix_en, pix_addr, pix_bit);
        end
        frame(c0, 2, 4, "R12 reset set is off");

        write_set(ca); frame(ca, 5, 24, "R1 R2 R3 R5 R6 R7 R8 1-bit");
        write_set(cb); frame(cb, 7, 32, "R3 R4 R5 R6 R7 2-bit zoom");
        write_set(cc); frame(cc, 6, 22, "R2 R4 R5 R6 R7 R8 4-bit");
        write_set(cd); frame(cd, 6, 26, "R2 R3 R4 R5 R6 8-bit wrap");
        write_set(ce); frame(ce, 3, 14, "R4 R5 R6 R7 R8 16-bit");
        write_set(cf); frame(cf, 4, 24, "R9 disabled");
        write_set(cg); frame(cg, 3, 22, "R9 reserved format");

        // R10 and R11: shadow rewritten after the frame starts; set ch stays active for 3 lines.
        write_set(ch);
        strobe(1'b1);
        write_set(ci);
        ticks(ch, 0, 18, "R10 R11 before reload");
        for (int y = 1; y < 3; y++) begin
            strobe(1'b0);
            ticks(ch, y, 18, "R10 R11 before reload");
        end
        for (int y = 3; y < 6; y++) begin
            strobe(1'b0);
            ticks(ci, y, 18, "R10 after reload");
        end

        repeat (3) @(negedge clk);
        done = 1'b1;
        if (sb.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL R13: got %0d unchecked items, expected 0", sb.size());
        end
        summary();
        $finish;
    end
endmodule